// File: doc/BRIEF.md
# SPI Transaction Verification Recorder

This block watches the decoded event stream of a serial register port and keeps a record of what the link last carried. It holds three values: the most recent command header, the most recent data word of a 16-bit transaction, and the most recent data word of a 32-bit transaction. A host reads these values back through a small register-read port and compares them with what it sent or received, which confirms that the link moved the bits it intended to move.

The header is captured on the cycle it is reported as fully received. The transaction's width is remembered from the header, and the data word is captured when the decoder strobes the end of the data phase. Reads and writes are recorded in the same way. A transaction whose header addresses one of the recorder's own registers updates nothing, so the host can read the record without disturbing it. The physical serial layer and the main register file are outside this block.

The header is a 16-bit word. Bits [15:4] carry the register address, bit 3 carries the read flag, and bits [2:0] carry remaining command bits. The recorder's registers decode at 0x4A3 (command), 0x4AC (16-bit data) and 0x423 (32-bit data).

Top module: `xact_recorder`

## Requirements
- R1: After reset, reads of all three recorder registers return zero.
- R2: A header whose address field (hdr_word[15:4]) is not a recorder address is stored on the clock edge where hdr_valid is high. A read of 0x4A3 returns the stored header zero-extended to 32 bits, with bits [2:0] forced to zero.
- R3: A data strobe in an open 16-bit transaction (hdr_wide was 0 at its header) stores data_word[15:0] as the 16-bit record. The 32-bit record is left unchanged. A read of 0x4AC returns the record zero-extended.
- R4: A data strobe in an open 32-bit transaction (hdr_wide was 1) stores data_word as the 32-bit record. The 16-bit record is left unchanged. A read of 0x423 returns the record.
- R5: Recording does not depend on the read flag (hdr_word[3]). Reads and writes are recorded alike.
- R6: A header whose address field equals 0x4A3, 0x4AC or 0x423 leaves all three records unchanged. This covers the header itself and that transaction's data strobe.
- R7: rd_en with rd_addr samples on a clock edge, and rd_data and rd_hit are valid after that edge. rd_hit is 1 only for the three recorder addresses. It is 0, with rd_data zero, for any other address or when rd_en was low.
- R8: A data strobe is accepted only once per header. A strobe that arrives before any header, or after the transaction's data was already taken, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 1 | Command header fully received this cycle |
| hdr_word | input | 16 | Received header: [15:4] address, [3] read flag, [2:0] other bits |
| hdr_wide | input | 1 | Transaction width given with the header: 1 = 32-bit, 0 = 16-bit |
| data_valid | input | 1 | End of the data phase of the open transaction |
| data_word | input | 32 | Data moved in the transaction (16-bit uses [15:0]) |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 12 | Register read address |
| rd_data | output | 32 | Read result, valid the cycle after the request |
| rd_hit | output | 1 | Read address matched a recorder register |

## Verification
The bench builds the block with the default parameters: a 12-bit address field at header bit 4, the read flag at bit 3, and three masked low bits. With these defaults the real recorder addresses fall within the random address pool, and about one header in six targets the recorder. Together with random widths and read flags, this brings the freeze rule, cross-width isolation and low-bit masking within reach in the same run. Directed steps add strobes before any header, duplicate strobes, and reads of unmapped addresses.

// File: rtl/xrec_pkg.sv
// Package: shared constants, register addresses and read-select type
// for the transaction recorder. Assumes a 12-bit register address space.
package xrec_pkg;
    localparam int ADDR_W = 12;
    localparam int CMD_W  = 16;
    localparam int DATA_W = 32;
    localparam int HALF_W = 16;

    localparam logic [ADDR_W-1:0] ADR_CMD = 12'h4A3;
    localparam logic [ADDR_W-1:0] ADR_D16 = 12'h4AC;
    localparam logic [ADDR_W-1:0] ADR_D32 = 12'h423;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_D16  = 2'd2,
        SEL_D32  = 2'd3
    } rec_sel_e;

    // Map an address to the recorder register it selects, if any.
    function automatic rec_sel_e rec_decode(input logic [ADDR_W-1:0] a);
        if (a == ADR_CMD)      return SEL_CMD;
        else if (a == ADR_D16) return SEL_D16;
        else if (a == ADR_D32) return SEL_D32;
        else                   return SEL_NONE;
    endfunction
endpackage

// File: rtl/xrec_hdr_track.sv
// Header tracker: stores the last non-recorder header and keeps the
// state of the open transaction (open flag, width). Assumes that one
// data strobe follows each header and that hdr_valid and data_valid
// do not coincide.
module xrec_hdr_track
    import xrec_pkg::*;
#(
    parameter int ADDR_LSB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_valid,
    input  logic [CMD_W-1:0] hdr_word,
    input  logic             hdr_wide,
    input  logic             data_valid,
    output logic [CMD_W-1:0] cmd_q,
    output logic             xact_open,
    output logic             xact_wide
);
    logic self_hit;

    // Does the incoming header address one of the recorder registers?
    always_comb begin
        self_hit = (rec_decode(hdr_word[ADDR_LSB +: ADDR_W]) != SEL_NONE);
    end

    // Header capture and transaction open/close bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            xact_open <= 1'b0;
            xact_wide <= 1'b0;
        end else if (hdr_valid) begin
            if (!self_hit) cmd_q <= hdr_word;
            xact_open <= !self_hit;
            xact_wide <= hdr_wide;
        end else if (data_valid) begin
            xact_open <= 1'b0;
        end
    end
endmodule

// File: rtl/xrec_data_reg.sv
// Data record register of width W: loads d when we is high.
// Assumes the caller has already qualified we with the transaction state.
module xrec_data_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Hold the record, loading on a qualified strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/xrec_read_port.sv
// Registered read port: decodes the read address and returns the
// selected record one cycle later, masking the low command bits.
// Assumes all records are presented zero-extended to DATA_W.
module xrec_read_port
    import xrec_pkg::*;
#(
    parameter int MASK_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CMD_W-1:0]  cmd_q,
    input  logic [DATA_W-1:0] d16_ext,
    input  logic [DATA_W-1:0] d32_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_hit
);
    localparam logic [CMD_W-1:0] CMD_KEEP =
        {{(CMD_W-MASK_BITS){1'b1}}, {MASK_BITS{1'b0}}};

    rec_sel_e    sel;
    logic [DATA_W-1:0] mux_val;

    // Select the addressed record.
    always_comb begin
        sel = rec_decode(rd_addr);
        unique case (sel)
            SEL_CMD: mux_val = DATA_W'(cmd_q & CMD_KEEP);
            SEL_D16: mux_val = d16_ext;
            SEL_D32: mux_val = d32_q;
            default: mux_val = '0;
        endcase
    end

    // Register the read result and the hit flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_hit  <= 1'b0;
        end else begin
            rd_data <= rd_en ? mux_val : '0;
            rd_hit  <= rd_en && (sel != SEL_NONE);
        end
    end
endmodule

// File: rtl/xact_recorder.sv
// Top: records last command header and last 16-/32-bit data words of
// a serial register link, freezing on accesses to its own registers.
// Assumes decoded header/data events from an upstream transaction decoder.
module xact_recorder
    import xrec_pkg::*;
#(
    parameter int ADDR_LSB  = 4,
    parameter int MASK_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_valid,
    input  logic [CMD_W-1:0]  hdr_word,
    input  logic              hdr_wide,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_word,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_hit
);
    localparam int NLANE = 2;

    logic [CMD_W-1:0]  cmd_q;
    logic              xact_open;
    logic              xact_wide;
    logic [DATA_W-1:0] lane_q [NLANE];
    logic [HALF_W-1:0] d16_q;
    logic [DATA_W-1:0] d32_q;

    xrec_hdr_track #(.ADDR_LSB(ADDR_LSB)) u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_valid (hdr_valid),
        .hdr_word  (hdr_word),
        .hdr_wide  (hdr_wide),
        .data_valid(data_valid),
        .cmd_q     (cmd_q),
        .xact_open (xact_open),
        .xact_wide (xact_wide)
    );

    // Lane 0 records 16-bit transactions, lane 1 records 32-bit ones.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int W = (g == 0) ? HALF_W : DATA_W;
        logic         we;
        logic [W-1:0] q;
        assign we = data_valid && !hdr_valid && xact_open && (xact_wide == (g == 1));
        xrec_data_reg #(.W(W)) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (we),
            .d    (data_word[W-1:0]),
            .q    (q)
        );
        assign lane_q[g] = DATA_W'(q);
    end

    assign d16_q = lane_q[0][HALF_W-1:0];
    assign d32_q = lane_q[1];

    xrec_read_port #(.MASK_BITS(MASK_BITS)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .cmd_q  (cmd_q),
        .d16_ext(lane_q[0]),
        .d32_q  (d32_q),
        .rd_data(rd_data),
        .rd_hit (rd_hit)
    );
endmodule

// File: rtl/xrec_checker.sv
// Checker: temporal properties of the recorder, bound to the top.
module xrec_checker
    import xrec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hdr_valid,
    input logic [CMD_W-1:0]  hdr_word,
    input logic              data_valid,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_hit,
    input logic [CMD_W-1:0]  cmd_q,
    input logic              xact_open,
    input logic              xact_wide,
    input logic [HALF_W-1:0] d16_q,
    input logic [DATA_W-1:0] d32_q
);
    logic hdr_self;
    assign hdr_self = rec_decode(hdr_word[15:4]) != SEL_NONE;

    p_cmd_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADR_CMD) |=> (rd_hit && rd_data[2:0] == 3'b000));

    p_narrow_keeps_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !hdr_valid && xact_open && !xact_wide) |=> $stable(d32_q));

    p_wide_keeps_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !hdr_valid && xact_open && xact_wide) |=> $stable(d16_q));

    p_freeze_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_self) |=> $stable(cmd_q));

    p_freeze_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_self) |=> !xact_open);

    p_hit_only_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_hit && rd_data == '0));

    p_stray_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !hdr_valid && !xact_open) |=> ($stable(d16_q) && $stable(d32_q)));
endmodule

bind xact_recorder xrec_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_valid (hdr_valid),
    .hdr_word  (hdr_word),
    .data_valid(data_valid),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rd_hit    (rd_hit),
    .cmd_q     (cmd_q),
    .xact_open (xact_open),
    .xact_wide (xact_wide),
    .d16_q     (d16_q),
    .d32_q     (d32_q)
);

// File: tb/xact_recorder_bench.sv
// Bench: directed corners plus seeded random transactions, checked
// against a behavioural model kept in bench variables.
module xact_recorder_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [15:0] hdr_word = '0;
    logic        hdr_wide = 1'b0;
    logic        data_valid = 1'b0;
    logic [31:0] data_word = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_hit;

    int n_chk = 0;
    int n_bad = 0;

    // Model state
    logic [15:0] m_cmd = '0;
    logic [15:0] m_d16 = '0;
    logic [31:0] m_d32 = '0;
    logic        m_open = 1'b0;
    logic        m_wide = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xact_recorder u_xact_recorder (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_word(hdr_word),
        .hdr_wide(hdr_wide), .data_valid(data_valid), .data_word(data_word),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_hit(rd_hit)
    );

    function automatic bit is_rec(input logic [11:0] a);
        return a == 12'h4A3 || a == 12'h4AC || a == 12'h423;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        if (a == 12'h4A3)      return {16'h0, m_cmd[15:3], 3'b000};
        else if (a == 12'h4AC) return {16'h0, m_d16};
        else if (a == 12'h423) return m_d32;
        else                   return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_hdr(input logic [11:0] a, input bit rd, input logic [2:0] lo, input bit wide);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_word = {a, rd, lo}; hdr_wide = wide;
        @(negedge clk);
        hdr_valid = 1'b0;
        if (!is_rec(a)) m_cmd = {a, rd, lo};
        m_open = !is_rec(a);
        m_wide = wide;
    endtask

    task automatic send_data(input logic [31:0] d);
        @(negedge clk);
        data_valid = 1'b1; data_word = d;
        @(negedge clk);
        data_valid = 1'b0;
        if (m_open) begin
            if (m_wide) m_d32 = d;
            else        m_d16 = d[15:0];
        end
        m_open = 1'b0;
    endtask

    task automatic do_read(input string tag, input logic [11:0] a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk);
        #1;
        check(tag, rd_data, exp_read(a));
        check({tag, " hit"}, {31'h0, rd_hit}, {31'h0, is_rec(a)});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_all(input string tag);
        do_read(tag, 12'h4A3);
        do_read(tag, 12'h4AC);
        do_read(tag, 12'h423);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        read_all("R1 reset");

        // R8: strobe with no header since reset
        send_data(32'hDEAD_BEEF);
        read_all("R8 strobe before header");

        // R2, R3: write 16-bit with nonzero low bits
        send_hdr(12'h120, 1'b0, 3'b111, 1'b0);
        send_data(32'hAAAA_1234);
        read_all("R2 R3 narrow write");

        // R4, R5: read 32-bit
        send_hdr(12'h7F0, 1'b1, 3'b101, 1'b1);
        send_data(32'hCAFE_F00D);
        read_all("R4 R5 wide read");

        // R8: duplicate strobe ignored
        send_data(32'h1111_2222);
        read_all("R8 duplicate strobe");

        // R6: header targeting each recorder register freezes everything
        send_hdr(12'h4A3, 1'b1, 3'b010, 1'b0);
        send_data(32'h5555_6666);
        read_all("R6 freeze cmd addr");
        send_hdr(12'h4AC, 1'b0, 3'b001, 1'b0);
        send_data(32'h7777_8888);
        read_all("R6 freeze d16 addr");
        send_hdr(12'h423, 1'b1, 3'b000, 1'b1);
        send_data(32'h9999_AAAA);
        read_all("R6 freeze d32 addr");

        // R7: unmapped reads and idle port
        do_read("R7 unmapped", 12'h000);
        do_read("R7 unmapped", 12'h4A4);
        @(posedge clk); #1;
        check("R7 idle data", rd_data, 32'h0);
        check("R7 idle hit", {31'h0, rd_hit}, 32'h0);

        // Random mix of widths, read flags and addresses (R2-R6)
        for (int i = 0; i < 300; i++) begin
            logic [11:0] a;
            int pick;
            pick = $urandom_range(0, 17);
            if (pick == 0)      a = 12'h4A3;
            else if (pick == 1) a = 12'h4AC;
            else if (pick == 2) a = 12'h423;
            else                a = 12'($urandom);
            send_hdr(a, 1'($urandom), 3'($urandom), 1'($urandom));
            send_data($urandom);
            if (i % 3 == 0) read_all("R2 R3 R4 R6 random");
            else do_read("R5 R6 random", 12'($urandom_range(0, 2) == 0 ? 12'h4A3 :
                                             ($urandom_range(0, 1) == 0 ? 12'h4AC : 12'h423)));
        end
        read_all("R6 final");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule